// File: doc/BRIEF.md
# Boot Remap Address Decoder

This block sits in front of a system interconnect and routes each master address to one of five destinations: boot static memory on chip select 0, boot static memory on chip select 1, dynamic memory, the external AXI port, or the fixed system map. An access that a master is not allowed to make raises a decode error instead.

Four address windows can be moved between destinations by a six-bit remap word. Bits [5:2] of that word pick one of five memory layouts by priority. A separate swap bit exchanges the two boot chip selects. Bits [1:0] limit which addresses the two processor cores and the low-latency peripheral port may reach. The remap word and the swap bit are held in a configuration register. A write to that register is applied only on a clock edge where no request is present, so a request never sees the layout change under it.

Each request is decoded combinationally and the result is registered. The result therefore appears one cycle after the request.

Top module: `remap_addr_decoder`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_target` and `rsp_err` are all 0, and the active configuration is remap word 0 with swap 0.
- R2: A request sampled with `req_valid` high at a clock edge produces `rsp_valid` high for exactly the following cycle. In that response exactly one of the following holds: a single `rsp_target` bit is set, or `rsp_err` is set. Target encoding: bit0 = static CS0, bit1 = static CS1, bit2 = dynamic memory, bit3 = external AXI, bit4 = fixed system map.
- R3: The four windows are W0 = 0x00000000–0x03FFFFFF, W1 = 0x04000000–0x3FFFFFFF, W2 = 0x60000000–0x7FFFFFFF and W3 = 0xC0000000–0xFFEFFFFF. When remap bits [5:2] are 0000, the windows route in order to boot static, dynamic, external and external.
- R4: When remap bit 2 is 1, whatever bits [5:3] hold, the windows route to dynamic, dynamic, external and external.
- R5: When remap bits [3:2] are 10, the windows route to external, external, dynamic and dynamic.
- R6: When remap bits [4:2] are 100, every window routes to dynamic memory.
- R7: When remap bits [5:2] are 1000, the windows route to boot static, dynamic, dynamic and dynamic.
- R8: Boot static means CS1 when the swap bit is 1 and CS0 when it is 0. The swap bit has no effect in the R4, R5 and R6 layouts.
- R9: An address outside all four windows routes to the fixed system map in every layout.
- R10: Master IDs are 0 = core 0, 1 = core 1, 2 = peripheral port, 3 = other. When remap bit 0 is 1, a core access outside 0x00000000–0x7FFFFFFF and 0xFF000000–0xFFFFFFFF gives `rsp_err` = 1 with `rsp_target` = 0.
- R11: When remap bit 1 is 1, a peripheral-port access below 0x80000000 gives `rsp_err` = 1 with `rsp_target` = 0. Master 3 is never restricted.
- R12: A configuration write made while `req_valid` is high does not change how that request or any following back-to-back request is decoded. It takes effect at the first edge where `req_valid` is low. A write made with `req_valid` low applies to a request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load the configuration from `cfg_remap` and `cfg_swap` |
| cfg_remap | input | 6 | New remap word |
| cfg_swap | input | 1 | New boot chip-select swap bit |
| req_valid | input | 1 | Address request present |
| req_addr | input | 32 | Request address |
| req_master | input | 2 | Requesting master ID |
| rsp_valid | output | 1 | Decode result valid |
| rsp_target | output | 5 | One-hot destination |
| rsp_err | output | 1 | Access denied |

## Verification
Each window is probed at both of its edges, together with the first address past each window. This separates the window arithmetic from the default route to the fixed map. The same probes are repeated under every layout, including remap words with extra high bits set, so a wrong decode priority routes a window to a visibly different destination. The swap bit is toggled under every layout to show that it matters only where boot static memory appears. Restricted and unrestricted masters send identical addresses, so a denial can only come from the master ID. A configuration write is issued during a run of back-to-back requests to show when it becomes active.

// File: rtl/remap_dec_pkg.sv
package remap_dec_pkg;

    localparam int NUM_TGT   = 5;
    localparam int TGT_CS0   = 0;
    localparam int TGT_CS1   = 1;
    localparam int TGT_DYN   = 2;
    localparam int TGT_EXT   = 3;
    localparam int TGT_FIX   = 4;
    localparam int REMAP_W   = 6;
    localparam int MASTER_W  = 2;

    typedef enum logic [2:0] {
        LAY_BOOT  = 3'd0,
        LAY_DYNLO = 3'd1,
        LAY_SWAP  = 3'd2,
        LAY_ALLDY = 3'd3,
        LAY_BTDYN = 3'd4
    } layout_e;

    typedef enum logic [MASTER_W-1:0] {
        MST_CORE0  = 2'd0,
        MST_CORE1  = 2'd1,
        MST_PERIPH = 2'd2,
        MST_OTHER  = 2'd3
    } master_e;

    typedef struct packed {
        logic [REMAP_W-1:0] remap;
        logic               swap;
    } cfg_t;

endpackage

// File: rtl/remap_cfg_reg.sv
module remap_cfg_reg
    import remap_dec_pkg::*;
#(
    parameter logic [REMAP_W-1:0] RST_REMAP = '0,
    parameter logic               RST_SWAP  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  cfg_t wr_cfg,
    input  logic busy,
    output cfg_t act_cfg
);

    typedef struct packed {
        cfg_t act;
        cfg_t stg;
        logic pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.stg  = wr_cfg;
            st_d.pend = 1'b1;
        end
        if (!busy && st_d.pend) begin
            st_d.act  = st_d.stg;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.act  <= '{remap: RST_REMAP, swap: RST_SWAP};
            st_q.stg  <= '{remap: RST_REMAP, swap: RST_SWAP};
            st_q.pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_cfg = st_q.act;

endmodule

// File: rtl/remap_window_map.sv
module remap_window_map
    import remap_dec_pkg::*;
#(
    parameter int          ADDR_W = 32,
    parameter logic [31:0] W0_HI  = 32'h03FF_FFFF,
    parameter logic [31:0] W1_HI  = 32'h3FFF_FFFF,
    parameter logic [31:0] W2_LO  = 32'h6000_0000,
    parameter logic [31:0] W2_HI  = 32'h7FFF_FFFF,
    parameter logic [31:0] W3_LO  = 32'hC000_0000,
    parameter logic [31:0] W3_HI  = 32'hFFEF_FFFF
) (
    input  logic [ADDR_W-1:0]  addr,
    input  cfg_t               cfg,
    output logic [NUM_TGT-1:0] tgt_oh
);

    localparam int NUM_WIN = 4;

    logic [NUM_WIN-1:0] in_win;
    layout_e            lay;
    int unsigned        boot_tgt;
    int unsigned        route [NUM_WIN];

    always_comb begin
        in_win[0] = (addr <= ADDR_W'(W0_HI));
        in_win[1] = (addr > ADDR_W'(W0_HI)) && (addr <= ADDR_W'(W1_HI));
        in_win[2] = (addr >= ADDR_W'(W2_LO)) && (addr <= ADDR_W'(W2_HI));
        in_win[3] = (addr >= ADDR_W'(W3_LO)) && (addr <= ADDR_W'(W3_HI));
    end

    always_comb begin
        if (cfg.remap[2])       lay = LAY_DYNLO;
        else if (cfg.remap[3])  lay = LAY_SWAP;
        else if (cfg.remap[4])  lay = LAY_ALLDY;
        else if (cfg.remap[5])  lay = LAY_BTDYN;
        else                    lay = LAY_BOOT;
    end

    always_comb begin
        boot_tgt = cfg.swap ? TGT_CS1 : TGT_CS0;
        unique case (lay)
            LAY_DYNLO: route = '{TGT_DYN, TGT_DYN, TGT_EXT, TGT_EXT};
            LAY_SWAP:  route = '{TGT_EXT, TGT_EXT, TGT_DYN, TGT_DYN};
            LAY_ALLDY: route = '{TGT_DYN, TGT_DYN, TGT_DYN, TGT_DYN};
            LAY_BTDYN: route = '{boot_tgt, TGT_DYN, TGT_DYN, TGT_DYN};
            default:   route = '{boot_tgt, TGT_DYN, TGT_EXT, TGT_EXT};
        endcase
    end

    always_comb begin
        tgt_oh = '0;
        tgt_oh[TGT_FIX] = ~|in_win;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (in_win[w]) tgt_oh[route[w]] = 1'b1;
        end
    end

endmodule

// File: rtl/remap_access_guard.sv
module remap_access_guard
    import remap_dec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TOP_W  = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [MASTER_W-1:0] master,
    input  logic [1:0]          limit,
    output logic                deny
);

    localparam logic [TOP_W-1:0] TOP_ALL = '1;

    logic upper_half;
    logic top_block;
    logic is_core;
    logic is_periph;

    always_comb begin
        upper_half = addr[ADDR_W-1];
        top_block  = (addr[ADDR_W-1 -: TOP_W] == TOP_ALL);
        is_core    = (master == MST_CORE0) || (master == MST_CORE1);
        is_periph  = (master == MST_PERIPH);
        deny       = (limit[0] && is_core && upper_half && !top_block)
                   || (limit[1] && is_periph && !upper_half);
    end

endmodule

// File: rtl/remap_addr_decoder.sv
module remap_addr_decoder
    import remap_dec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [REMAP_W-1:0]  cfg_remap,
    input  logic                cfg_swap,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [MASTER_W-1:0] req_master,
    output logic                rsp_valid,
    output logic [NUM_TGT-1:0]  rsp_target,
    output logic                rsp_err
);

    typedef struct packed {
        logic               vld;
        logic [NUM_TGT-1:0] tgt;
        logic               err;
    } rsp_t;

    cfg_t               act_cfg;
    logic [REMAP_W-1:0] act_remap;
    logic [NUM_TGT-1:0] win_tgt;
    logic               deny;
    rsp_t               rsp_d, rsp_q;

    remap_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .wr_cfg  ('{remap: cfg_remap, swap: cfg_swap}),
        .busy    (req_valid),
        .act_cfg (act_cfg)
    );

    assign act_remap = act_cfg.remap;

    remap_window_map #(.ADDR_W(ADDR_W)) u_map (
        .addr   (req_addr),
        .cfg    (act_cfg),
        .tgt_oh (win_tgt)
    );

    remap_access_guard #(.ADDR_W(ADDR_W)) u_guard (
        .addr   (req_addr),
        .master (req_master),
        .limit  (act_cfg.remap[1:0]),
        .deny   (deny)
    );

    always_comb begin
        rsp_d     = '0;
        rsp_d.vld = req_valid;
        if (req_valid) begin
            rsp_d.err = deny;
            rsp_d.tgt = deny ? '0 : win_tgt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid  = rsp_q.vld;
    assign rsp_target = rsp_q.tgt;
    assign rsp_err    = rsp_q.err;

endmodule

// File: rtl/remap_dec_chk.sv
module remap_dec_chk
    import remap_dec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [MASTER_W-1:0] req_master,
    input logic                rsp_valid,
    input logic [NUM_TGT-1:0]  rsp_target,
    input logic                rsp_err,
    input logic [REMAP_W-1:0]  act_remap
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_target == '0 && !rsp_err));

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (($countones(rsp_target) == 1) != rsp_err));

    // R9
    fixed_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_master == MST_OTHER && req_addr[31:29] == 3'b010)
        |=> (rsp_target == NUM_TGT'(1 << TGT_FIX)));

    // R10
    core_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && act_remap[0] && req_master inside {MST_CORE0, MST_CORE1}
         && req_addr[31] && req_addr[31:24] != 8'hFF) |=> rsp_err);

    // R11
    periph_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && act_remap[1] && req_master == MST_PERIPH && !req_addr[31])
        |=> rsp_err);

    // R12
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> $stable(act_remap));

endmodule

bind remap_addr_decoder remap_dec_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_master (req_master),
    .rsp_valid  (rsp_valid),
    .rsp_target (rsp_target),
    .rsp_err    (rsp_err),
    .act_remap  (act_remap)
);

// File: tb/test_remap_addr_decoder.sv
module test_remap_addr_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_remap = '0;
    logic        cfg_swap = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_master = '0;
    logic        rsp_valid;
    logic [4:0]  rsp_target;
    logic        rsp_err;

    always #2.5 clk = ~clk;

    remap_addr_decoder i_remap_addr_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_remap(cfg_remap),
        .cfg_swap(cfg_swap), .req_valid(req_valid), .req_addr(req_addr),
        .req_master(req_master), .rsp_valid(rsp_valid),
        .rsp_target(rsp_target), .rsp_err(rsp_err)
    );

    typedef struct {
        logic [4:0] tgt;
        logic       err;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    int         n_chk = 0;
    int         n_fail = 0;
    logic [5:0] m_remap = '0;
    logic       m_swap = 1'b0;
    bit         done = 0;

    localparam logic [4:0] CS0 = 5'b00001, CS1 = 5'b00010, DYN = 5'b00100,
                           EXT = 5'b01000, FIX = 5'b10000;

    function automatic exp_t model(input logic [31:0] a, input logic [1:0] m,
                                   input string tag);
        exp_t e;
        logic [4:0] boot, w0, w1, w2, w3;
        e.tag = tag;
        e.err = 1'b0;
        e.tgt = '0;
        if (m_remap[0] && m <= 2'd1 && a >= 32'h8000_0000 && a < 32'hFF00_0000)
            e.err = 1'b1;
        if (m_remap[1] && m == 2'd2 && a < 32'h8000_0000)
            e.err = 1'b1;
        boot = m_swap ? CS1 : CS0;
        if (m_remap[2])      begin w0 = DYN;  w1 = DYN; w2 = EXT; w3 = EXT; end
        else if (m_remap[3]) begin w0 = EXT;  w1 = EXT; w2 = DYN; w3 = DYN; end
        else if (m_remap[4]) begin w0 = DYN;  w1 = DYN; w2 = DYN; w3 = DYN; end
        else if (m_remap[5]) begin w0 = boot; w1 = DYN; w2 = DYN; w3 = DYN; end
        else                 begin w0 = boot; w1 = DYN; w2 = EXT; w3 = EXT; end
        if (!e.err) begin
            if (a <= 32'h03FF_FFFF)                            e.tgt = w0;
            else if (a <= 32'h3FFF_FFFF)                       e.tgt = w1;
            else if (a >= 32'h6000_0000 && a <= 32'h7FFF_FFFF) e.tgt = w2;
            else if (a >= 32'hC000_0000 && a <= 32'hFFEF_FFFF) e.tgt = w3;
            else                                               e.tgt = FIX;
        end
        return e;
    endfunction

    task automatic issue(input logic [31:0] a, input logic [1:0] m, input string tag);
        @(negedge clk);
        cfg_wr = 1'b0;
        req_valid = 1'b1;
        req_addr = a;
        req_master = m;
        sb.push_back(model(a, m, tag));
    endtask

    task automatic issue_wr(input logic [31:0] a, input logic [1:0] m,
                            input logic [5:0] r, input logic s, input string tag);
        issue(a, m, tag);
        cfg_wr = 1'b1;
        cfg_remap = r;
        cfg_swap = s;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cfg_wr = 1'b0;
            req_valid = 1'b0;
        end
    endtask

    task automatic set_cfg(input logic [5:0] r, input logic s);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_wr = 1'b1;
        cfg_remap = r;
        cfg_swap = s;
        m_remap = r;
        m_swap = s;
    endtask

    task automatic probe_windows(input string tag);
        issue(32'h0000_0000, 2'd3, tag);
        issue(32'h03FF_FFFF, 2'd3, tag);
        issue(32'h0400_0000, 2'd3, tag);
        issue(32'h3FFF_FFFF, 2'd3, tag);
        issue(32'h6000_0000, 2'd3, tag);
        issue(32'h7FFF_FFFF, 2'd3, tag);
        issue(32'hC000_0000, 2'd3, tag);
        issue(32'hFFEF_FFFF, 2'd3, tag);
        issue(32'h4000_0000, 2'd3, "R9");
        issue(32'h5FFF_FFFF, 2'd3, "R9");
        issue(32'h8000_0000, 2'd3, "R9");
        issue(32'hFFF0_0000, 2'd3, "R9");
    endtask

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_chk++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R2 unexpected response target=%b err=%b expected none",
                         rsp_target, rsp_err);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_target !== e.tgt || rsp_err !== e.err) begin
                    n_fail++;
                    $display("FAIL %s target=%b err=%b expected target=%b err=%b",
                             e.tag, rsp_target, rsp_err, e.tgt, e.err);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired target=%b err=%b expected completion",
                     rsp_target, rsp_err);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (rsp_valid !== 1'b0 || rsp_target !== 5'b0 || rsp_err !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset outputs valid=%b target=%b err=%b expected 0 0 0",
                     rsp_valid, rsp_target, rsp_err);
        end
        // R1 reset layout is the default one with swap 0
        issue(32'h0000_0100, 2'd3, "R1");
        // R3 default layout, window edges
        probe_windows("R3");
        set_cfg(6'b000000, 1'b1);
        probe_windows("R8");
        // R4 including higher bits set
        set_cfg(6'b000100, 1'b0);
        probe_windows("R4");
        set_cfg(6'b111100, 1'b1);
        probe_windows("R4");
        // R5
        set_cfg(6'b001000, 1'b1);
        probe_windows("R5");
        set_cfg(6'b101000, 1'b0);
        probe_windows("R5");
        // R6
        set_cfg(6'b010000, 1'b1);
        probe_windows("R6");
        set_cfg(6'b110000, 1'b0);
        probe_windows("R6");
        // R7 with both swap values
        set_cfg(6'b100000, 1'b0);
        probe_windows("R7");
        set_cfg(6'b100000, 1'b1);
        probe_windows("R8");
        // R10 core restriction
        set_cfg(6'b000001, 1'b0);
        for (int m = 0; m < 4; m++) begin
            issue(32'h8000_0000, 2'(m), "R10");
            issue(32'hFEFF_FFFF, 2'(m), "R10");
            issue(32'hFF00_0000, 2'(m), "R10");
            issue(32'h7FFF_FFFF, 2'(m), "R10");
        end
        // R11 peripheral restriction
        set_cfg(6'b000010, 1'b0);
        for (int m = 0; m < 4; m++) begin
            issue(32'h7FFF_FFFF, 2'(m), "R11");
            issue(32'h0000_0000, 2'(m), "R11");
            issue(32'h8000_0000, 2'(m), "R11");
        end
        set_cfg(6'b000011, 1'b0);
        issue(32'h9000_0000, 2'd0, "R10");
        issue(32'h1000_0000, 2'd2, "R11");
        issue(32'h9000_0000, 2'd2, "R11");
        // R12 write during back-to-back requests is deferred
        set_cfg(6'b000000, 1'b0);
        issue_wr(32'h0000_0000, 2'd3, 6'b010000, 1'b1, "R12");
        issue(32'h0000_0000, 2'd3, "R12");
        issue(32'h6000_0000, 2'd3, "R12");
        idle(1);
        m_remap = 6'b010000;
        m_swap = 1'b1;
        issue(32'h0000_0000, 2'd3, "R12");
        issue(32'h6000_0000, 2'd3, "R12");
        idle(4);
        n_chk++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R2 missing responses left=%0d expected 0", sb.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule